// File: doc/BRIEF.md
# Video Controller Register Access Port

This block is the processor-side front end of a video display controller's control registers. A small bus gives access to a bank of 47 eight-bit registers. The bus has a 2-bit port select, a chip select, one-cycle read and write strobes and an 8-bit write data byte. The registers are written in one of two ways:

- **Direct path.** Two consecutive writes go to the setup port. The value comes first and the register number second.
- **Indirect path.** Writes go to the indirect port. A pointer held in register 17 selects the target, and it can step forward after every write.

The whole register bank is brought out as a flat vector for the rest of the controller. A read of the setup port returns an externally supplied status byte. It also resynchronises the two-write sequence. Video memory data, palette storage and the status contents are handled elsewhere; writes to those ports leave this block untouched.

Top module: `vid_reg_port`

## Requirements
- R1: A synchronous reset clears all 47 registers to 0x00 and puts the setup-port sequence in the first-byte phase.
- R2: On port 1 (portSel = 2'b01), a first write supplies a value. A second write with bits 7:6 = 2'b10 stores that value into the register numbered by its bits 5:0, on the clock edge of that second write.
- R3: Each port 1 write toggles the phase. A second byte whose bit 7 is 0 is an address setup: it changes no register and leaves the next write as a first byte.
- R4: While cs and rdStb are high with portSel = 2'b01, rdData equals statusIn; otherwise rdData is 0x00. Such a read returns the sequence to the first-byte phase.
- R5: A write aimed at a register number from 47 to 63, on either path, changes no register.
- R6: A port 3 (portSel = 2'b11) write stores its byte into the register selected by bits 5:0 of register 17. When bit 7 of register 17 is 0, those six bits then step by one, wrapping from 63 to 0 with bits 7:6 kept.
- R7: When bit 7 of register 17 is 1, port 3 writes leave register 17 unchanged.
- R8: A port 3 write while the pointer selects register 17 does not store its byte into register 17. The pointer still follows R6/R7.
- R9: Writes to port 0 or port 2, and any write with cs low, change no register and leave the phase as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select qualifying both strobes |
| portSel | input | 2 | Port number: 0 memory data, 1 setup/status, 2 palette, 3 indirect |
| wrStb | input | 1 | One-cycle write strobe, one per write |
| rdStb | input | 1 | One-cycle read strobe |
| wrData | input | 8 | Write data byte |
| statusIn | input | 8 | Status byte supplied by the controller |
| rdData | output | 8 | Read data, status on a port 1 read |
| regsOut | output | 376 | Register bank, register n in bits 8n+7:8n |

## Verification
The assertions take for granted three things about the inputs:
- A read strobe and a write strobe are never high in the same cycle.
- Each strobe pulse lasts exactly one clock, so that one pulse means one access.
- The first byte of a sequence is never issued while a port 1 read is pending.

The bench drives every access from a task that raises the strobe for one cycle on a falling edge and drops it on the next falling edge. Reads and writes are issued strictly one after another, so no stimulus leaves those bounds.

// File: rtl/vid_reg_port_pkg.sv
package vid_reg_port_pkg;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] PORT_MEM   = 2'd0;
  localparam logic [1:0] PORT_SETUP = 2'd1;
  localparam logic [1:0] PORT_PAL   = 2'd2;
  localparam logic [1:0] PORT_INDIR = 2'd3;

  // strobes from control to datapath for the current cycle
  typedef struct packed {
    logic             latchData; // capture first byte of a direct write
    logic             regWr;     // write one register
    logic             useLatch;  // value from latch (direct) or bus (indirect)
    logic [IDX_W-1:0] regSel;    // target register number
    logic             ptrStep;   // advance the pointer field
  } reg_cmd_t;
endpackage

// File: rtl/vid_reg_port_ctrl.sv
module vid_reg_port_ctrl
  import vid_reg_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 47,
  parameter int unsigned PTR_REG  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [1:0]        portSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] ptrVal,
  output reg_cmd_t          cmd,
  output logic              phaseQ
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] PTR_IDX  = IDX_W'(PTR_REG);

  logic rdHit, setupWr, setupRd, indirWr;
  logic [IDX_W-1:0] ptrIdx;

  assign rdHit   = cs & rdStb;
  assign setupRd = rdHit & (portSel == PORT_SETUP);
  assign setupWr = cs & wrStb & ~rdHit & (portSel == PORT_SETUP);
  assign indirWr = cs & wrStb & ~rdHit & (portSel == PORT_INDIR);
  assign ptrIdx  = ptrVal[IDX_W-1:0];

  always_comb begin
    cmd = '0;
    if (setupWr && !phaseQ) begin
      cmd.latchData = 1'b1;
    end else if (setupWr && phaseQ) begin
      // register setup only for the 2'b10 tag and an existing register
      if (wrData[7:6] == 2'b10 && wrData[IDX_W-1:0] <= LAST_IDX) begin
        cmd.regWr    = 1'b1;
        cmd.useLatch = 1'b1;
        cmd.regSel   = wrData[IDX_W-1:0];
      end
    end else if (indirWr) begin
      if (ptrIdx <= LAST_IDX && ptrIdx != PTR_IDX) begin
        cmd.regWr  = 1'b1;
        cmd.regSel = ptrIdx;
      end
      cmd.ptrStep = ~ptrVal[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          phaseQ <= 1'b0;
    else if (setupRd) phaseQ <= 1'b0;
    else if (setupWr) phaseQ <= ~phaseQ;
  end
endmodule

// File: rtl/vid_reg_port_regfile.sv
module vid_reg_port_regfile
  import vid_reg_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 47,
  parameter int unsigned PTR_REG  = 17
) (
  input  logic                       clk,
  input  logic                       rst,
  input  reg_cmd_t                   cmd,
  input  logic [BYTE_W-1:0]          wrData,
  output logic [NUM_REGS*BYTE_W-1:0] regsFlat,
  output logic [BYTE_W-1:0]          ptrVal
);
  logic [BYTE_W-1:0] dataLatch;
  logic [BYTE_W-1:0] writeVal;
  logic [BYTE_W-1:0] regQ [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst)                dataLatch <= '0;
    else if (cmd.latchData) dataLatch <= wrData;
  end

  assign writeVal = cmd.useLatch ? dataLatch : wrData;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == PTR_REG) begin : g_ptr
      always_ff @(posedge clk) begin
        if (rst)
          regQ[i] <= '0;
        else if (cmd.regWr && cmd.regSel == IDX_W'(i))
          regQ[i] <= writeVal;
        else if (cmd.ptrStep)
          regQ[i] <= {regQ[i][BYTE_W-1:IDX_W], regQ[i][IDX_W-1:0] + 1'b1};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          regQ[i] <= '0;
        else if (cmd.regWr && cmd.regSel == IDX_W'(i))
          regQ[i] <= writeVal;
      end
    end
    assign regsFlat[i*BYTE_W +: BYTE_W] = regQ[i];
  end

  assign ptrVal = regQ[PTR_REG];
endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
  import vid_reg_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 47,
  parameter int unsigned PTR_REG  = 17
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs,
  input  logic [1:0]                 portSel,
  input  logic                       wrStb,
  input  logic                       rdStb,
  input  logic [7:0]                 wrData,
  input  logic [7:0]                 statusIn,
  output logic [7:0]                 rdData,
  output logic [NUM_REGS*8-1:0]      regsOut
);
  reg_cmd_t          cmd;
  logic              phase;
  logic [BYTE_W-1:0] ptrVal;

  vid_reg_port_ctrl #(.NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG)) u_ctrl (
    .clk(clk), .rst(rst), .cs(cs), .portSel(portSel), .wrStb(wrStb),
    .rdStb(rdStb), .wrData(wrData), .ptrVal(ptrVal), .cmd(cmd),
    .phaseQ(phase)
  );

  vid_reg_port_regfile #(.NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG)) u_regs (
    .clk(clk), .rst(rst), .cmd(cmd), .wrData(wrData),
    .regsFlat(regsOut), .ptrVal(ptrVal)
  );

  assign rdData = (cs && rdStb && portSel == PORT_SETUP) ? statusIn : 8'h00;
endmodule

// File: rtl/vid_reg_port_chk.sv
module vid_reg_port_chk #(
  parameter int unsigned NUM_REGS = 47,
  parameter int unsigned PTR_REG  = 17
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs,
  input logic [1:0]            portSel,
  input logic                  wrStb,
  input logic                  rdStb,
  input logic [7:0]            wrData,
  input logic [NUM_REGS*8-1:0] regsOut,
  input logic                  phase
);
  logic [7:0] ptr;
  logic wrAny, setupWr, indirWr;
  assign ptr     = regsOut[PTR_REG*8 +: 8];
  assign wrAny   = cs && wrStb && !rdStb;
  assign setupWr = wrAny && portSel == 2'd1;
  assign indirWr = wrAny && portSel == 2'd3;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (regsOut == '0 && !phase));

  a_r3_phase_toggle: assert property (@(posedge clk) disable iff (rst)
    setupWr |=> phase != $past(phase));

  a_r4_read_resyncs: assert property (@(posedge clk) disable iff (rst)
    (cs && rdStb && portSel == 2'd1) |=> !phase);

  a_r5_high_index_dropped: assert property (@(posedge clk) disable iff (rst)
    (setupWr && phase && wrData[7:6] == 2'b10 && int'(wrData[5:0]) >= NUM_REGS)
    |=> $stable(regsOut));

  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    (indirWr && !ptr[7] && int'(ptr[5:0]) != PTR_REG)
    |=> ptr == {$past(ptr[7:6]), $past(ptr[5:0]) + 6'd1});

  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (indirWr && ptr[7]) |=> $stable(ptr));

  a_r8_self_target: assert property (@(posedge clk) disable iff (rst)
    (indirWr && int'(ptr[5:0]) == PTR_REG && !ptr[7])
    |=> ptr == {$past(ptr[7:6]), $past(ptr[5:0]) + 6'd1});

  a_r9_other_ports_inert: assert property (@(posedge clk) disable iff (rst)
    (wrAny && (portSel == 2'd0 || portSel == 2'd2)) |=> ($stable(regsOut) && $stable(phase)));
endmodule

bind vid_reg_port vid_reg_port_chk #(.NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG)) i_chk (
  .clk(clk), .rst(rst), .cs(cs), .portSel(portSel), .wrStb(wrStb),
  .rdStb(rdStb), .wrData(wrData), .regsOut(regsOut), .phase(phase)
);

// File: tb/test_vid_reg_port.sv
module test_vid_reg_port;
  localparam int NR = 47;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, wrStb = 1'b0, rdStb = 1'b0;
  logic [1:0] portSel = 2'd0;
  logic [7:0] wrData = 8'h00, statusIn = 8'h00, rdData;
  logic [NR*8-1:0] regsOut;
  int testCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  vid_reg_port i_vid_reg_port (
    .clk(clk), .rst(rst), .cs(cs), .portSel(portSel), .wrStb(wrStb),
    .rdStb(rdStb), .wrData(wrData), .statusIn(statusIn), .rdData(rdData),
    .regsOut(regsOut)
  );

  function automatic logic [7:0] rg(input int n);
    return regsOut[n*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBank(input string req, input logic [NR*8-1:0] exp);
    testCnt++;
    if (regsOut !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, regsOut, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d, input logic c = 1'b1);
    @(negedge clk); cs = c; portSel = p; wrData = d; wrStb = 1'b1;
    @(negedge clk); cs = 1'b0; wrStb = 1'b0;
  endtask

  task automatic setReg(input int n, input logic [7:0] d);
    wr(2'd1, d);
    wr(2'd1, 8'h80 | 8'(n));
  endtask

  task automatic t_reset();
    setReg(5, 8'hAB);
    wr(2'd1, 8'h12);               // leave phase at second byte
    doReset();
    chkBank("R1 bank cleared", '0);
    setReg(9, 8'h3C);              // works only if phase was cleared
    chk("R1 phase cleared", rg(9), 8'h3C);
  endtask

  task automatic t_direct();
    doReset();
    setReg(3, 8'h5A);
    chk("R2 reg3", rg(3), 8'h5A);
    setReg(46, 8'hC3);
    chk("R2 reg46", rg(46), 8'hC3);
    setReg(0, 8'hFF);
    chk("R2 reg0", rg(0), 8'hFF);
    wr(2'd1, 8'h77); wr(2'd1, 8'hC4); // tag 2'b11: not a register setup
    chk("R2 tag11 ignored", rg(4), 8'h00);
  endtask

  task automatic t_addrSetup();
    logic [NR*8-1:0] snap;
    doReset();
    snap = regsOut;
    wr(2'd1, 8'h11); wr(2'd1, 8'h05);
    chkBank("R3 address setup no change", snap);
    wr(2'd1, 8'h22); wr(2'd1, 8'h87);
    chk("R3 phase back to first", rg(7), 8'h22);
  endtask

  task automatic t_read();
    doReset();
    statusIn = 8'h9D;
    chk("R4 idle rdData", rdData, 8'h00);
    wr(2'd1, 8'h33);
    @(negedge clk); cs = 1'b1; portSel = 2'd1; rdStb = 1'b1;
    #1 chk("R4 status read", rdData, 8'h9D);
    @(negedge clk); cs = 1'b0; rdStb = 1'b0;
    #1 chk("R4 rdData after read", rdData, 8'h00);
    wr(2'd1, 8'h44); wr(2'd1, 8'h88);
    chk("R4 read resets phase", rg(8), 8'h44);
  endtask

  task automatic t_range();
    logic [NR*8-1:0] snap;
    doReset();
    snap = regsOut;
    wr(2'd1, 8'h5E); wr(2'd1, 8'hAF);   // register 47
    wr(2'd1, 8'h5E); wr(2'd1, 8'hBF);   // register 63
    chkBank("R5 direct high index dropped", snap);
    setReg(17, 8'h2E);                  // pointer 46, stepping
    wr(2'd3, 8'h99);
    chk("R5 reg46 via pointer", rg(46), 8'h99);
    snap = regsOut;
    wr(2'd3, 8'h77);                    // pointer 47: dropped
    snap[17*8 +: 8] = 8'h30;
    chkBank("R5 indirect high index dropped", snap);
  endtask

  task automatic t_autoInc();
    doReset();
    setReg(17, 8'h14);
    wr(2'd3, 8'hA0); wr(2'd3, 8'hA1); wr(2'd3, 8'hA2);
    chk("R6 reg20", rg(20), 8'hA0);
    chk("R6 reg21", rg(21), 8'hA1);
    chk("R6 reg22", rg(22), 8'hA2);
    chk("R6 pointer advanced", rg(17), 8'h17);
    setReg(17, 8'h3F);
    wr(2'd3, 8'h01);
    chk("R6 wrap to 0", rg(17), 8'h00);
    wr(2'd3, 8'h5B);
    chk("R6 reg0 after wrap", rg(0), 8'h5B);
    setReg(17, 8'h7F);
    wr(2'd3, 8'h02);
    chk("R6 wrap keeps bit6", rg(17), 8'h40);
  endtask

  task automatic t_hold();
    doReset();
    setReg(17, 8'h85);
    wr(2'd3, 8'h10); wr(2'd3, 8'h20);
    chk("R7 reg5 overwritten", rg(5), 8'h20);
    chk("R7 pointer held", rg(17), 8'h85);
    chk("R7 reg6 untouched", rg(6), 8'h00);
  endtask

  task automatic t_self();
    doReset();
    setReg(17, 8'h11);
    wr(2'd3, 8'hEE);
    chk("R8 self target steps", rg(17), 8'h12);
    setReg(17, 8'h91);
    wr(2'd3, 8'hEE);
    chk("R8 self target held", rg(17), 8'h91);
  endtask

  task automatic t_otherPorts();
    logic [NR*8-1:0] snap;
    doReset();
    snap = regsOut;
    wr(2'd1, 8'h66);          // first byte
    wr(2'd0, 8'h81);          // memory data port
    wr(2'd2, 8'h81);          // palette port
    wr(2'd1, 8'h81, 1'b0);    // deselected
    chkBank("R9 no register change", snap);
    wr(2'd1, 8'h82);
    chk("R9 phase kept", rg(2), 8'h66);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct();
    t_addrSetup();
    t_read();
    t_range();
    t_autoInc();
    t_hold();
    t_self();
    t_otherPorts();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule